// File: doc/BRIEF.md
# Front-End Configuration Command Decoder

This block receives configuration commands for one 64-channel front-end chip over a serial command line and keeps the chip's configuration. It holds three 64-bit channel masks (trigger, calibration, data), a small mode register and a register with two 7-bit DAC codes. Every one of these can be written by a command and read back serially. A separate command fires a single-cycle calibrate strobe toward the charge-injection circuit. The masks and DAC codes leave the block as plain buses for the analog part of the chip.

Two command decoders are built, one for the right-hand port and one for the left-hand port. Both feed a single register set. A bit in the mode register picks the decoder that is obeyed, and the other decoder is held idle. Every frame carries an odd-parity bit, and a frame that fails the check is dropped. The failure is remembered in a sticky flag that can be read back. A readback shifts a snapshot of the register, so the register itself does not change. Both ports are sampled on the one block clock.

Top module: `feCfgDecoder`

## Requirements
- R1: While reset is asserted and after it is released, all three masks and both DAC codes are zero, the right-hand decoder is selected, the error flag is clear, readEnable is 0 and calStrobe is 0.
- R2: A frame on the idle-low line is a 1 start bit, then 5 address bits MSB first, then 4 opcode bits MSB first, then 64 payload bits MSB first (only for opcodes 1 to 5), then a parity bit. The count of ones over address, opcode, payload and parity must be odd.
- R3: Load opcodes act on the edge that samples the parity bit. Opcode 1 loads the trigger mask, 2 the calibration mask and 3 the data mask, each from the whole payload. Opcode 4 loads the mode register, where payload bit 0 sets the side (1 = left, 0 = right). Opcode 5 loads the DAC register, with payload bits 6:0 going to the threshold code and bits 13:7 to the calibration code.
- R4: Read opcodes 9 to 13 select, in order, the trigger mask, the calibration mask, the data mask, the mode register and the DAC register. The selected register is shifted out MSB first on readLine, one bit per clock, for exactly 64 cycles starting the cycle after the parity edge, and readEnable is high for exactly those cycles. Narrow registers are zero-extended to 64 bits. Mode readback carries the side in bit 0 and the error flag in bit 1. DAC readback uses the same layout as the DAC load.
- R5: Reading a register leaves its contents unchanged, and a second read returns the same bits.
- R6: Loads and calibrate commands execute when the address equals chipAddr or equals 31. Reads execute only on an exact match with chipAddr, so a broadcast read produces no output.
- R7: A frame with bad parity that is addressed to the chip (exact match or 31) is not executed and sets the error flag. Only reset clears the flag.
- R8: Opcode 7 drives calStrobe high for exactly one cycle, the cycle after the parity edge.
- R9: Only the selected decoder acts. Frames on the other line have no effect. After a switch of side, the newly selected decoder starts looking for a start bit.
- R10: A read that completes while an earlier readback is still shifting aborts that readback. The new register's 64 bits follow at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, samples both command lines |
| rstN | input | 1 | Active-low asynchronous reset |
| chipAddr | input | 5 | Address of this chip |
| cmdRight | input | 1 | Serial command line, right-hand port |
| cmdLeft | input | 1 | Serial command line, left-hand port |
| readLine | output | 1 | Serial readback, high impedance when not reading |
| readEnable | output | 1 | High while readLine is driven |
| calStrobe | output | 1 | One-cycle calibrate pulse |
| thrCode | output | 7 | Threshold DAC code |
| calCode | output | 7 | Calibration DAC code |
| trigMask | output | 64 | Trigger channel mask |
| calMask | output | 64 | Calibration channel mask |
| dataMask | output | 64 | Data channel mask |

## Verification
The serial readback and the command decoder run at the same time. A second command can finish while a 64-bit readback is still shifting, so a reload and a shift can fall in the same cycle. The bench provokes this by sending a short read frame right after a trigger-mask read, and also a calibrate frame during a readback. A scoreboard queue holds the expected readback bits. When a read frame completes, the driver discards the bits still pending and pushes the new register's 64 bits. The monitor compares readLine and readEnable with the queue on every falling edge, so a lost restart, a doubled bit or a stray enable shows up at the exact cycle it happens.

// File: rtl/fecfg_pkg.sv
package fecfg_pkg;
  localparam int NUM_REGS     = 5;
  localparam int IDX_TRIG     = 0;
  localparam int IDX_CALM     = 1;
  localparam int IDX_DATA     = 2;
  localparam int IDX_MODE     = 3;
  localparam int IDX_DAC      = 4;
  localparam int OP_LOAD_BASE = 1;
  localparam int OP_READ_BASE = 9;
  localparam int OP_CALIB     = 7;

  typedef struct packed {
    logic [NUM_REGS-1:0] load;
    logic [NUM_REGS-1:0] read;
    logic                calib;
    logic                parErr;
  } cmdStrobe_t;
endpackage

// File: rtl/cmdDecoder.sv
module cmdDecoder
  import fecfg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int OP_W   = 4,
  parameter int PAY_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              cmdIn,
  input  logic [ADDR_W-1:0] chipAddr,
  output cmdStrobe_t        strobe,
  output logic [PAY_W-1:0]  payload
);
  localparam int HDR_W = ADDR_W + OP_W;
  localparam int MAX_N = (PAY_W > HDR_W) ? PAY_W : HDR_W;
  localparam int CNT_W = $clog2(MAX_N) + 1;
  localparam logic [ADDR_W-1:0] BCAST = '1;

  typedef enum logic [1:0] {S_IDLE, S_HEAD, S_BODY, S_PAR} decState_e;

  decState_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [HDR_W-1:0]  hdr;
  logic              parAcc;

  logic [OP_W-1:0]   opNow;
  logic [OP_W-1:0]   opCode;
  logic [ADDR_W-1:0] addrCode;
  logic              hit, exact, parOk;

  function automatic logic isLoadOp(input logic [OP_W-1:0] op);
    return (op >= OP_W'(OP_LOAD_BASE)) && (op < OP_W'(OP_LOAD_BASE + NUM_REGS));
  endfunction

  assign opNow    = {hdr[OP_W-2:0], cmdIn};
  assign opCode   = hdr[OP_W-1:0];
  assign addrCode = hdr[HDR_W-1 -: ADDR_W];
  assign exact    = (addrCode == chipAddr);
  assign hit      = exact || (addrCode == BCAST);
  assign parOk    = parAcc ^ cmdIn;

  always_comb begin
    strobe = '0;
    if (enable && state == S_PAR && hit) begin
      if (!parOk) begin
        strobe.parErr = 1'b1;
      end else begin
        for (int r = 0; r < NUM_REGS; r++) begin
          if (opCode == OP_W'(OP_LOAD_BASE + r)) strobe.load[r] = 1'b1;
          if (exact && opCode == OP_W'(OP_READ_BASE + r)) strobe.read[r] = 1'b1;
        end
        if (opCode == OP_W'(OP_CALIB)) strobe.calib = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      cnt     <= '0;
      hdr     <= '0;
      payload <= '0;
      parAcc  <= 1'b0;
    end else if (!enable) begin
      state <= S_IDLE;
    end else begin
      case (state)
        S_IDLE: if (cmdIn) begin
          state  <= S_HEAD;
          cnt    <= '0;
          parAcc <= 1'b0;
        end
        S_HEAD: begin
          hdr    <= {hdr[HDR_W-2:0], cmdIn};
          parAcc <= parAcc ^ cmdIn;
          if (cnt == CNT_W'(HDR_W - 1)) begin
            cnt   <= '0;
            state <= isLoadOp(opNow) ? S_BODY : S_PAR;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        S_BODY: begin
          payload <= {payload[PAY_W-2:0], cmdIn};
          parAcc  <= parAcc ^ cmdIn;
          if (cnt == CNT_W'(PAY_W - 1)) state <= S_PAR;
          else                          cnt   <= cnt + CNT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (state == S_IDLE))
    else $error("deselected decoder left idle");

  assert_bad_parity_blocks_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.parErr |-> (strobe.load == '0 && strobe.read == '0 && !strobe.calib))
    else $error("command executed despite parity error");

  assert_single_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.read, strobe.calib}))
    else $error("more than one action per frame");
endmodule

// File: rtl/cfgRegFile.sv
module cfgRegFile
  import fecfg_pkg::*;
#(
  parameter int MASK_W = 64,
  parameter int DAC_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strb,
  input  logic [MASK_W-1:0] payload,
  output logic [MASK_W-1:0] trigMask,
  output logic [MASK_W-1:0] calMask,
  output logic [MASK_W-1:0] dataMask,
  output logic [DAC_W-1:0]  thrCode,
  output logic [DAC_W-1:0]  calCode,
  output logic              sideLeft,
  output logic              errFlag,
  output logic              readBit,
  output logic              readEnable,
  output logic              calStrobe
);
  localparam int RCNT_W = $clog2(MASK_W + 1);

  logic [MASK_W-1:0] shReg;
  logic [MASK_W-1:0] snap;
  logic [RCNT_W-1:0] rdCnt;

  always_comb begin
    snap = '0;
    if (strb.read[IDX_TRIG]) snap = trigMask;
    if (strb.read[IDX_CALM]) snap = calMask;
    if (strb.read[IDX_DATA]) snap = dataMask;
    if (strb.read[IDX_MODE]) snap = {{(MASK_W-2){1'b0}}, errFlag, sideLeft};
    if (strb.read[IDX_DAC])  snap = {{(MASK_W-2*DAC_W){1'b0}}, calCode, thrCode};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigMask  <= '0;
      calMask   <= '0;
      dataMask  <= '0;
      thrCode   <= '0;
      calCode   <= '0;
      sideLeft  <= 1'b0;
      errFlag   <= 1'b0;
      calStrobe <= 1'b0;
    end else begin
      if (strb.load[IDX_TRIG]) trigMask <= payload;
      if (strb.load[IDX_CALM]) calMask  <= payload;
      if (strb.load[IDX_DATA]) dataMask <= payload;
      if (strb.load[IDX_MODE]) sideLeft <= payload[0];
      if (strb.load[IDX_DAC]) begin
        thrCode <= payload[DAC_W-1:0];
        calCode <= payload[2*DAC_W-1:DAC_W];
      end
      if (strb.parErr) errFlag <= 1'b1;
      calStrobe <= strb.calib;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shReg <= '0;
      rdCnt <= '0;
    end else if (|strb.read) begin
      shReg <= snap;
      rdCnt <= RCNT_W'(MASK_W);
    end else if (rdCnt != '0) begin
      shReg <= {shReg[MASK_W-2:0], 1'b0};
      rdCnt <= rdCnt - RCNT_W'(1);
    end
  end

  assign readBit    = shReg[MASK_W-1];
  assign readEnable = (rdCnt != '0);

  assert_cal_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    calStrobe |=> !calStrobe)
    else $error("calibrate strobe longer than one cycle");

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag)
    else $error("error flag cleared without reset");

  assert_read_starts_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|strb.read) |=> readEnable)
    else $error("readback did not start");

  assert_masks_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strb.load == '0) |=> $stable({trigMask, calMask, dataMask, thrCode, calCode}))
    else $error("configuration changed without a load");
endmodule

// File: rtl/feCfgDecoder.sv
module feCfgDecoder
  import fecfg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int OP_W   = 4,
  parameter int MASK_W = 64,
  parameter int DAC_W  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] chipAddr,
  input  logic              cmdRight,
  input  logic              cmdLeft,
  output wire               readLine,
  output logic              readEnable,
  output logic              calStrobe,
  output logic [DAC_W-1:0]  thrCode,
  output logic [DAC_W-1:0]  calCode,
  output logic [MASK_W-1:0] trigMask,
  output logic [MASK_W-1:0] calMask,
  output logic [MASK_W-1:0] dataMask
);
  localparam int NUM_SIDES = 2;

  logic [NUM_SIDES-1:0] cmdLines;
  cmdStrobe_t           sideStrobe [NUM_SIDES];
  logic [MASK_W-1:0]    sidePayload [NUM_SIDES];
  cmdStrobe_t           selStrobe;
  logic [MASK_W-1:0]    selPayload;
  logic                 sideLeft, errFlag, readBit;

  assign cmdLines = {cmdLeft, cmdRight};

  for (genvar s = 0; s < NUM_SIDES; s++) begin : gSide
    cmdDecoder #(.ADDR_W(ADDR_W), .OP_W(OP_W), .PAY_W(MASK_W)) decoder_i (
      .clk      (clk),
      .rstN     (rstN),
      .enable   (sideLeft == (s == 1)),
      .cmdIn    (cmdLines[s]),
      .chipAddr (chipAddr),
      .strobe   (sideStrobe[s]),
      .payload  (sidePayload[s])
    );
  end

  assign selStrobe  = sideLeft ? sideStrobe[1]  : sideStrobe[0];
  assign selPayload = sideLeft ? sidePayload[1] : sidePayload[0];

  cfgRegFile #(.MASK_W(MASK_W), .DAC_W(DAC_W)) regs_i (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (selStrobe),
    .payload    (selPayload),
    .trigMask   (trigMask),
    .calMask    (calMask),
    .dataMask   (dataMask),
    .thrCode    (thrCode),
    .calCode    (calCode),
    .sideLeft   (sideLeft),
    .errFlag    (errFlag),
    .readBit    (readBit),
    .readEnable (readEnable),
    .calStrobe  (calStrobe)
  );

  assign readLine = readEnable ? readBit : 1'bz;
endmodule

// File: tb/feCfgDecoder_tb_top.sv
module feCfgDecoder_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  chipAddr = 5'd9;
  logic        cmdRight, cmdLeft;
  wire         readLine;
  logic        readEnable, calStrobe;
  logic [6:0]  thrCode, calCode;
  logic [63:0] trigMask, calMask, dataMask;

  always #4 clk = ~clk;

  feCfgDecoder dut_i (
    .clk(clk), .rstN(rstN), .chipAddr(chipAddr), .cmdRight(cmdRight), .cmdLeft(cmdLeft),
    .readLine(readLine), .readEnable(readEnable), .calStrobe(calStrobe),
    .thrCode(thrCode), .calCode(calCode), .trigMask(trigMask), .calMask(calMask),
    .dataMask(dataMask)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit running = 0;
  bit done    = 0;
  bit expQ[$];
  bit expCal = 0;

  logic [63:0] mTrig = '0, mCal = '0, mData = '0;
  logic [6:0]  mThr = '0, mCalC = '0;
  bit          mSide = 0, mErr = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] modelView(int r);
    case (r)
      0: return mTrig;
      1: return mCal;
      2: return mData;
      3: return {62'b0, mErr, mSide};
      default: return {50'b0, mCalC, mThr};
    endcase
  endfunction

  // scoreboard monitor: readback bits and calibrate pulse (R4, R8, R10)
  always @(negedge clk) begin
    if (running && rstN) begin
      if (expQ.size() > 0) begin
        check("R4 readEnable", {63'b0, readEnable}, 64'd1);
        check("R4/R10 readLine bit", {63'b0, readLine}, {63'b0, expQ[0]});
        void'(expQ.pop_front());
      end else begin
        check("R4 readEnable idle", {63'b0, readEnable}, 64'd0);
      end
      check("R8 calStrobe", {63'b0, calStrobe}, {63'b0, expCal});
      expCal = 0;
    end
  end

  // driver: sends one frame and updates the model from the requirements (R2)
  task automatic sendFrame(bit left, logic [4:0] addr, logic [3:0] op,
                           logic [63:0] pay, bit badPar);
    bit frame[$];
    int ones = 0;
    bit isLoad = (op >= 4'd1 && op <= 4'd5);
    bit hit, exact;
    frame.push_back(1'b1);
    for (int i = 4; i >= 0; i--) frame.push_back(addr[i]);
    for (int i = 3; i >= 0; i--) frame.push_back(op[i]);
    if (isLoad) for (int i = 63; i >= 0; i--) frame.push_back(pay[i]);
    for (int i = 1; i < frame.size(); i++) ones += frame[i];
    frame.push_back(((ones % 2) == 0) ^ badPar);
    foreach (frame[i]) begin
      @(negedge clk);
      if (left) cmdLeft = frame[i]; else cmdRight = frame[i];
    end
    @(posedge clk); #1;
    cmdLeft = 0; cmdRight = 0;
    exact = (addr == chipAddr);
    hit = exact || (addr == 5'd31);
    if (left == mSide && hit) begin
      if (badPar) mErr = 1;
      else if (isLoad) begin
        case (op)
          4'd1: mTrig = pay;
          4'd2: mCal  = pay;
          4'd3: mData = pay;
          4'd4: mSide = pay[0];
          default: begin mThr = pay[6:0]; mCalC = pay[13:7]; end
        endcase
      end else if (op >= 4'd9 && op <= 4'd13 && exact) begin
        logic [63:0] v = modelView(int'(op) - 9);
        expQ.delete();
        for (int i = 63; i >= 0; i--) expQ.push_back(v[i]);
      end else if (op == 4'd7) expCal = 1;
    end
  endtask

  task automatic waitQuiet();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic checkRegs(string req);
    @(negedge clk);
    check({req, " trigMask"}, trigMask, mTrig);
    check({req, " calMask"}, calMask, mCal);
    check({req, " dataMask"}, dataMask, mData);
    check({req, " DAC codes"}, {50'b0, calCode, thrCode}, {50'b0, mCalC, mThr});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=running expected=finished");
    finishRun();
  end

  initial begin
    rstN = 0; cmdRight = 0; cmdLeft = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkRegs("R1");
    check("R1 readEnable", {63'b0, readEnable}, 64'd0);
    check("R1 calStrobe", {63'b0, calStrobe}, 64'd0);
    rstN = 1;
    running = 1;
    @(negedge clk);

    // R2, R3: loads of every register
    sendFrame(0, 5'd9, 4'd1, 64'hA5F0_0123_4567_89CE, 0); checkRegs("R3 trig");
    sendFrame(0, 5'd9, 4'd2, 64'h8000_0000_0000_0001, 0); checkRegs("R3 cal");
    sendFrame(0, 5'd9, 4'd3, 64'hFFFF_0000_FFFF_0000, 0); checkRegs("R3 data");
    sendFrame(0, 5'd9, 4'd5, {50'h3_1234_5678_9AB, 7'h4A, 7'h35}, 0); checkRegs("R3 dac");

    // R4, R5: readback of each register, twice for the trigger mask
    sendFrame(0, 5'd9, 4'd9, '0, 0);  waitQuiet(); checkRegs("R5 after read");
    sendFrame(0, 5'd9, 4'd9, '0, 0);  waitQuiet();
    sendFrame(0, 5'd9, 4'd10, '0, 0); waitQuiet();
    sendFrame(0, 5'd9, 4'd11, '0, 0); waitQuiet();
    sendFrame(0, 5'd9, 4'd13, '0, 0); waitQuiet();
    sendFrame(0, 5'd9, 4'd12, '0, 0); waitQuiet();

    // R6: broadcast load, broadcast read, foreign address
    sendFrame(0, 5'd31, 4'd3, 64'h0F0F_1E1E_2D2D_3C3C, 0); checkRegs("R6 bcast load");
    sendFrame(0, 5'd31, 4'd11, '0, 0); waitQuiet();
    check("R6 bcast read silent", {63'b0, readEnable}, 64'd0);
    sendFrame(0, 5'd4, 4'd1, 64'h1111_2222_3333_4444, 0); checkRegs("R6 foreign addr");

    // R7: bad parity dropped, flag seen in mode readback
    sendFrame(0, 5'd9, 4'd1, 64'hDEAD_BEEF_0000_FFFF, 1); checkRegs("R7 bad parity");
    sendFrame(0, 5'd9, 4'd12, '0, 0); waitQuiet();

    // R8: calibrate strobe, also during a readback
    sendFrame(0, 5'd9, 4'd7, '0, 0); waitQuiet();
    sendFrame(0, 5'd9, 4'd9, '0, 0);
    sendFrame(0, 5'd31, 4'd7, '0, 0); waitQuiet();

    // R9: other side ignored, then switch to left
    sendFrame(1, 5'd9, 4'd1, 64'h7777_7777_7777_7777, 0); checkRegs("R9 left ignored");
    sendFrame(0, 5'd9, 4'd4, 64'd1, 0);
    sendFrame(0, 5'd9, 4'd2, 64'h5555_AAAA_5555_AAAA, 0); checkRegs("R9 right ignored");
    sendFrame(1, 5'd9, 4'd2, 64'h0123_4567_89AB_CDEF, 0); checkRegs("R9 left active");
    sendFrame(1, 5'd9, 4'd12, '0, 0); waitQuiet();

    // R10: read completing during a readback restarts it
    sendFrame(1, 5'd9, 4'd9, '0, 0);
    sendFrame(1, 5'd9, 4'd13, '0, 0); waitQuiet();
    check("R10 queue drained", {32'b0, 32'(expQ.size())}, 64'd0);

    finishRun();
  end
endmodule